// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the bit-level engine of a target device on a two-wire serial bus. It samples the external clock and data lines through synchronisers. It shifts data into an 8-bit register on each rising clock edge and counts every clock edge, rising and falling, in a 4-bit counter. It also detects start and stop conditions on the bus. A local controller drives the block through three write strobes that share one write-data bus. It reads the data register and a status word back at any time.

The counter counts both edges, so the value written to it sets the length of a transfer. A value of 0 gives a full byte of 16 edges. A value of 14 gives a single acknowledge bit of 2 edges. Two events can stretch the bus clock by pulling SCL low until software clears their flag: a start condition, and, in the holding mode, a counter overflow. This lets firmware examine each byte at its own pace. SDA is driven open-drain from a copy of the register's top bit. That copy changes only while SCL is low.

Top module: `tw_serial_unit`

## Requirements
- R1: After reset, the status word, the data register, both line pulls and both interrupt requests are all zero.
- R2: While enabled, each rising SCL edge shifts the data register one place left and puts the sampled SDA level into bit 0, so a byte arrives MSB first.
- R3: While enabled, the counter (status bits 3:0) advances on every SCL edge. On the edge that takes it from 15 to 0 it sets the overflow flag. A preset of 0 overflows after 16 edges and a preset of 14 overflows after 2 edges.
- R4: SDA falling while SCL is high sets the start flag (status bit 7) and clears the counter. Once SCL is low, SCL is pulled low for as long as the start flag stays set.
- R5: SDA rising while SCL is high sets the stop flag (status bit 5). The stop flag never holds SCL.
- R6: With control mode 3 (control bits 3:2), a set overflow flag (status bit 6) holds SCL low once SCL is low. With mode 2, an overflow does not hold SCL.
- R7: A status write clears each flag whose write-data bit is 1 and leaves a flag unchanged where the bit is 0. The same write loads write-data bits 3:0 into the counter. A flag event in the same cycle takes priority over the clear.
- R8: The start interrupt request equals the start flag gated by control bit 0. The overflow interrupt request equals the overflow flag gated by control bit 1.
- R9: SDA is pulled low only when the direction bit (control bit 4) is 1 and the latched output bit is 0. The latched bit follows the data register MSB while SCL is low and holds its value while SCL is high.
- R10: If the direction bit is 1, the latched output bit is 1 and SDA is sampled low on a rising SCL edge, the collision flag (status bit 4) is set.
- R11: With mode 0 or 1 the unit is off. It does no shifting, counting or flag setting, and it releases both lines.
- R12: A data write loads the data register, and the register reads back on the data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| ctrl_we | input | 1 | Write strobe for the control register |
| stat_we | input | 1 | Write strobe for flag clear and counter preset |
| data_we | input | 1 | Write strobe for the data register |
| wdata | input | 8 | Shared write data |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| rd_data | output | 8 | Data register contents |
| rd_stat | output | 8 | Flags in bits 7:4 (start, overflow, stop, collision), counter in bits 3:0 |
| irq_start | output | 1 | Start interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A miscounted edge counter is visible within one bit time. The overflow flag then rises on the wrong SCL edge, and in the holding mode SCL is stretched at the wrong point. Either error shows in the status word a few clocks after that edge. A wrong shift or latch value makes SDA carry a wrong bit during the next SCL low phase, or leaves a wrong byte in the data register. A stuck hold state leaves SCL pulled low after its flag has been cleared. The stimulus is arranged so that each of these symptoms is sampled once the synchroniser latency has passed.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_OFF_ALT = 2'b01,
        MODE_TW      = 2'b10,
        MODE_TW_HOLD = 2'b11
    } tw_mode_e;

    // control word: bit4 dir, bits3:2 mode, bit1 ovf_ie, bit0 start_ie
    typedef struct packed {
        logic     sda_dir;
        tw_mode_e mode;
        logic     ovf_ie;
        logic     start_ie;
    } tw_ctrl_t;

    localparam int CTRL_W = 5;

    // flag nibble placed above the counter in the status word
    typedef struct packed {
        logic start;
        logic ovf;
        logic stop;
        logic coll;
    } tw_flags_t;

    localparam int FLAG_W = 4;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } tw_line_ev_t;

    typedef struct packed {
        tw_ctrl_t  ctrl;
        tw_flags_t flags;
        logic      hold;
    } tw_top_state_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {(STAGES*W){RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/tw_linemon.sv
module tw_linemon
    import tw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_s,
    input  logic        sda_s,
    output tw_line_ev_t ev
);

    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d       = scl_s;
        sda_d       = sda_s;
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        // data line moves while the clock stays high on both samples
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

endmodule

// File: rtl/tw_edgecount.sv
module tw_edgecount #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_ev,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d = preset;
        end else if (en && restart) begin
            cnt_d = '0;
        end else if (en && edge_ev) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = (cnt_q == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tw_shiftreg.sv
module tw_shiftreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              sda_lvl,
    input  logic              sda_dir,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              pull_low,
    output logic              collide
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              out_bit;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.data = wdata;
        end else if (en && scl_rise) begin
            st_d.data = {st_q.data[DATA_W-2:0], sda_lvl};
        end
        // output copy is transparent only in the clock low phase
        if (!scl_lvl) begin
            st_d.out_bit = st_q.data[DATA_W-1];
        end
        collide  = en & scl_rise & sda_dir & st_q.out_bit & ~sda_lvl;
        pull_low = en & sda_dir & ~st_q.out_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data    <= '0;
            st_q.out_bit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;

endmodule

// File: rtl/tw_serial_unit.sv
module tw_serial_unit
    import tw_pkg::*;
#(
    parameter  int DATA_W  = 8,
    parameter  int CNT_W   = 4,
    parameter  int SYNC_N  = 2,
    localparam int STAT_W  = CNT_W + FLAG_W,
    localparam int WD_W    = (DATA_W > STAT_W) ? DATA_W : STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic              data_we,
    input  logic [WD_W-1:0]   wdata,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] rd_stat,
    output logic              irq_start,
    output logic              irq_ovf
);

    logic [1:0]       line_s;
    tw_line_ev_t      ev;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             collide;
    logic             en;
    tw_flags_t        clr;
    tw_top_state_t    st_d, st_q;

    tw_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );

    tw_linemon u_mon (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_s(line_s[1]),
        .sda_s(line_s[0]),
        .ev   (ev)
    );

    tw_edgecount #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .edge_ev(ev.scl_rise | ev.scl_fall),
        .restart(ev.start),
        .load   (stat_we),
        .preset (wdata[CNT_W-1:0]),
        .cnt_q  (cnt_q),
        .wrap   (wrap)
    );

    tw_shiftreg #(.DATA_W(DATA_W)) u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .scl_lvl (ev.scl_lvl),
        .scl_rise(ev.scl_rise),
        .sda_lvl (ev.sda_lvl),
        .sda_dir (st_q.ctrl.sda_dir),
        .wr      (data_we),
        .wdata   (wdata[DATA_W-1:0]),
        .data_q  (rd_data),
        .pull_low(sda_pull),
        .collide (collide)
    );

    assign en = (st_q.ctrl.mode == MODE_TW) || (st_q.ctrl.mode == MODE_TW_HOLD);

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl = tw_ctrl_t'(wdata[CTRL_W-1:0]);
        end
        clr = stat_we ? tw_flags_t'(wdata[STAT_W-1 -: FLAG_W]) : '0;
        st_d.flags = tw_flags_t'(st_q.flags & ~clr);
        // events win over a simultaneous software clear
        if (en && ev.start) st_d.flags.start = 1'b1;
        if (en && ev.stop)  st_d.flags.stop  = 1'b1;
        if (wrap)           st_d.flags.ovf   = 1'b1;
        if (collide)        st_d.flags.coll  = 1'b1;
        st_d.hold = en && !ev.scl_lvl &&
                    (st_d.flags.start ||
                     ((st_q.ctrl.mode == MODE_TW_HOLD) && st_d.flags.ovf));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_pull  = st_q.hold;
    assign rd_stat   = {st_q.flags, cnt_q};
    assign irq_start = st_q.flags.start & st_q.ctrl.start_ie;
    assign irq_ovf   = st_q.flags.ovf & st_q.ctrl.ovf_ie;

endmodule

// File: rtl/tw_serial_unit_chk.sv
module tw_serial_unit_chk
    import tw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input tw_mode_e         mode,
    input logic             sda_dir,
    input logic             scl_pull,
    input logic             sda_pull,
    input tw_flags_t        flags,
    input logic [CNT_W-1:0] cnt,
    input logic             stat_we,
    input logic             scl_edge,
    input logic             line_start
);

    logic mode_off;
    assign mode_off = (mode == MODE_OFF) || (mode == MODE_OFF_ALT);

    // R11
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_off && $past(mode_off)) |-> (!scl_pull && !sda_pull));

    // R9
    sda_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> sda_dir);

    // R4
    start_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags.start) && !$past(stat_we)) |-> (cnt == '0));

    // R6
    hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> (flags.start || flags.ovf));

    // R3
    cnt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt != $past(cnt)) && !$past(stat_we) && !$past(line_start)) |-> $past(scl_edge));

    // R5
    stop_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.stop) |-> !scl_pull);

endmodule

bind tw_serial_unit tw_serial_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (st_q.ctrl.mode),
    .sda_dir   (st_q.ctrl.sda_dir),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .flags     (st_q.flags),
    .cnt       (cnt_q),
    .stat_we   (stat_we),
    .scl_edge  (ev.scl_rise | ev.scl_fall),
    .line_start(ev.start)
);

// File: tb/tw_serial_unit_test.sv
module tw_serial_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       ctrl_we = 1'b0, stat_we = 1'b0, data_we = 1'b0;
    logic [7:0] wdata = '0;
    logic       scl_pull, sda_pull, irq_start, irq_ovf;
    logic [7:0] rd_data, rd_stat;
    logic       scl_bus, sda_bus;
    int         vectors = 0;
    int         miscomp = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_pull;
    assign sda_bus = sda_m & ~sda_pull;

    tw_serial_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_bus),
        .sda_i    (sda_bus),
        .ctrl_we  (ctrl_we),
        .stat_we  (stat_we),
        .data_we  (data_we),
        .wdata    (wdata),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .rd_data  (rd_data),
        .rd_stat  (rd_stat),
        .irq_start(irq_start),
        .irq_ovf  (irq_ovf)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
        wait_n(4);
    endtask

    task automatic wr_stat(input logic [7:0] v);
        @(negedge clk); stat_we = 1'b1; wdata = v;
        @(negedge clk); stat_we = 1'b0;
        wait_n(4);
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; wdata = v;
        @(negedge clk); data_we = 1'b0;
        wait_n(4);
    endtask

    // one bus bit, starting and ending with SCL low
    task automatic bus_bit(input logic b);
        sda_m = b;  wait_n(8);
        scl_m = 1'b1; wait_n(8);
        scl_m = 1'b0; wait_n(8);
    endtask

    task automatic t_reset;
        chk("R1 stat", rd_stat, 8'h00);
        chk("R1 data", rd_data, 8'h00);
        chk("R1 pulls", {scl_pull, sda_pull}, 2'b00);
        chk("R1 irqs", {irq_start, irq_ovf}, 2'b00);
    endtask

    task automatic t_start;
        wr_ctrl(8'h09);            // mode 2, start_ie
        wr_stat(8'h05);            // preset 5
        chk("R7 preset load", rd_stat, 8'h05);
        sda_m = 1'b0; wait_n(8);   // start with SCL high
        chk("R4 start flag, count cleared", rd_stat, 8'h80);
        chk("R8 start irq", irq_start, 1);
        chk("R4 no hold while SCL high", scl_pull, 0);
        scl_m = 1'b0; wait_n(8);
        chk("R4 hold after SCL low", scl_pull, 1);
        chk("R3 falling edge counted", rd_stat[3:0], 1);
        wr_stat(8'h80);
        chk("R4 hold released", scl_pull, 0);
        chk("R7 start cleared", rd_stat, 8'h00);
        chk("R8 irq dropped", irq_start, 0);
    endtask

    task automatic t_rx;
        logic [7:0] b = 8'hA5;
        wr_ctrl(8'h0E);            // mode 3, ovf_ie
        for (int i = 7; i >= 4; i--) bus_bit(b[i]);
        chk("R3 eight edges", rd_stat, 8'h08);
        for (int i = 3; i >= 0; i--) bus_bit(b[i]);
        chk("R2 byte received", rd_data, 8'hA5);
        chk("R3 overflow at 16 edges", rd_stat, 8'h40);
        chk("R6 overflow holds SCL", scl_pull, 1);
        chk("R8 ovf irq", irq_ovf, 1);
    endtask

    task automatic t_ack;
        wr_data(8'h00);
        wr_ctrl(8'h1E);            // dir out, mode 3, ovf_ie
        wr_stat(8'h4E);            // clear ovf, preset 14
        chk("R6 hold released", scl_pull, 0);
        chk("R9 ack pulls SDA", sda_pull, 1);
        chk("R3 preset 14", rd_stat, 8'h0E);
        sda_m = 1'b1;
        scl_m = 1'b1; wait_n(8);
        chk("R9 SDA low on bus", sda_bus, 0);
        scl_m = 1'b0; wait_n(8);
        chk("R3 overflow after 2 edges", rd_stat, 8'h40);
    endtask

    task automatic t_tx;
        logic [7:0] b = 8'h3C;
        wr_data(b);
        wr_stat(8'h40);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_n(8);
            chk("R9 transmit bit", sda_bus, int'(b[i]));
            scl_m = 1'b1; wait_n(8);
            scl_m = 1'b0; wait_n(8);
        end
        chk("R10 no collision, R3 overflow", rd_stat, 8'h40);
        chk("R2 own bits shifted back", rd_data, 8'h3C);
    endtask

    task automatic t_coll;
        wr_data(8'hFF);
        wr_stat(8'h40);
        bus_bit(1'b0);
        chk("R10 collision flag", rd_stat, 8'h12);
        wr_stat(8'h03);
        chk("R7 zero leaves flag, preset loads", rd_stat, 8'h13);
        wr_stat(8'h10);
        chk("R7 one clears collision", rd_stat, 8'h00);
    endtask

    task automatic t_stop;
        wr_ctrl(8'h08);            // mode 2, dir in
        chk("R9 released when dir in", sda_pull, 0);
        sda_m = 1'b0; wait_n(8);
        scl_m = 1'b1; wait_n(8);
        sda_m = 1'b1; wait_n(8);
        chk("R5 stop flag", rd_stat[7:4], 4'h2);
        chk("R5 stop no hold", scl_pull, 0);
        wr_stat(8'h20);
        chk("R7 stop cleared", rd_stat[7:4], 4'h0);
        scl_m = 1'b0; wait_n(8);
    endtask

    task automatic t_nohold;
        wr_stat(8'hFE);
        bus_bit(1'b1);
        chk("R6 mode 2 overflow flag", rd_stat, 8'h40);
        chk("R6 mode 2 no hold", scl_pull, 0);
        chk("R8 ovf irq masked", irq_ovf, 0);
        wr_ctrl(8'h0A);
        chk("R8 ovf irq enabled", irq_ovf, 1);
    endtask

    task automatic t_off;
        wr_ctrl(8'h10);            // mode 0, dir out
        wr_data(8'h00);
        wr_stat(8'hF0);
        chk("R11 SDA released when off", sda_pull, 0);
        bus_bit(1'b1);
        bus_bit(1'b1);
        scl_m = 1'b1; wait_n(8);
        sda_m = 1'b0; wait_n(8);
        chk("R11 no count or flags", rd_stat, 8'h00);
        chk("R11 no shift", rd_data, 8'h00);
        chk("R11 SCL released", scl_pull, 0);
        sda_m = 1'b1; wait_n(8);
        wr_data(8'h5A);
        chk("R12 data write", rd_data, 8'h5A);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_start();
        t_rx();
        t_ack();
        t_tx();
        t_coll();
        t_stop();
        t_nohold();
        t_off();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscomp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

endmodule